// File: doc/BRIEF.md
# Parallel-Select Slice Multiplexer with Optional Safe Fallback

The block chooses one word out of a packed bank of N equal slices, or a separate default word, according to an N-bit select vector in which each bit stands for one slice. It is purely combinational, so the output follows the inputs within the same evaluation with no clock and no stored state. It fits where a decoder upstream already produces one enable per source and the chosen word feeds straight into downstream logic.

A build-time mode parameter sets how overlapping selects are resolved. In plain mode the asserted bit with the largest index wins. In safe mode any select vector with two or more bits set returns the default word instead. With no select bit set, both modes return the default word. There is no data stream here, so there is no valid/ready pair and no back-pressure: every pin is a plain level.

Top module: `slice_select_mux`

## Requirements
- R1: Slice k of `bank_i` occupies bits k*WIDTH up to k*WIDTH+WIDTH-1. With exactly bit k of `pick_i` set, `word_o` equals slice k in plain mode.
- R2: With `pick_i` all zero, `word_o` equals `fallback_i` in both modes.
- R3: In plain mode (MODE = MUX_PLAIN), with two or more bits of `pick_i` set, `word_o` equals the slice whose index is the highest set bit.
- R4: In safe mode (MODE = MUX_SAFE), with two or more bits of `pick_i` set, `word_o` equals `fallback_i`.
- R5: In safe mode, with exactly bit k of `pick_i` set, `word_o` equals slice k.
- R6: `word_o` depends only on the present inputs. Applying an input set again gives the same output whatever was applied before, and the output settles with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fallback_i | input | WIDTH | Default word, returned when no valid selection exists |
| bank_i | input | SLOTS*WIDTH | Packed slices; slice k sits at bits k*WIDTH upward |
| pick_i | input | SLOTS | One select bit per slice |
| word_o | output | WIDTH | Selected word |

## Verification
The checks take every input to be a fully known 0/1 value whenever the output is compared. They also take an input change to be seen together with the output that has settled from it. The expected slice is found from the select vector alone, so the checks rely on every select pattern, including those with several bits set, being legal input. The stimulus drives each complete input set in one step and then waits for a short delay before any comparison. It uses slice values that differ from each other and from the default, so every wrong choice shows at the output.

// File: rtl/slice_mux_pkg.sv
package slice_mux_pkg;
  typedef enum logic {
    MUX_PLAIN = 1'b0,
    MUX_SAFE  = 1'b1
  } mux_mode_e;
endpackage

// File: rtl/pick_census.sv
// Reports whether two or more select bits are set, using a linear chain.
module pick_census #(
  parameter int SLOTS = 4
) (
  input  logic [SLOTS-1:0] pick_i,
  output logic             many_o
);
  logic [SLOTS:0] seen;
  logic [SLOTS:0] dup;

  assign seen[0] = 1'b0;
  assign dup[0]  = 1'b0;

  for (genvar k = 0; k < SLOTS; k++) begin : g_chain
    assign seen[k+1] = seen[k] | pick_i[k];
    assign dup[k+1]  = dup[k] | (seen[k] & pick_i[k]);
  end

  assign many_o = dup[SLOTS];
endmodule

// File: rtl/top_index_pick.sv
// Chain of 2:1 stages; a later (higher) set bit overrides earlier ones.
module top_index_pick #(
  parameter int WIDTH = 8,
  parameter int SLOTS = 4
) (
  input  logic [WIDTH-1:0]       fallback_i,
  input  logic [SLOTS*WIDTH-1:0] bank_i,
  input  logic [SLOTS-1:0]       pick_i,
  output logic [WIDTH-1:0]       word_o
);
  logic [WIDTH-1:0] stage [SLOTS+1];

  assign stage[0] = fallback_i;

  for (genvar k = 0; k < SLOTS; k++) begin : g_stage
    assign stage[k+1] = pick_i[k] ? bank_i[k*WIDTH +: WIDTH] : stage[k];
  end

  assign word_o = stage[SLOTS];
endmodule

// File: rtl/slice_select_mux.sv
module slice_select_mux
  import slice_mux_pkg::*;
#(
  parameter int        WIDTH = 8,
  parameter int        SLOTS = 4,
  parameter mux_mode_e MODE  = MUX_PLAIN
) (
  input  logic [WIDTH-1:0]       fallback_i,
  input  logic [SLOTS*WIDTH-1:0] bank_i,
  input  logic [SLOTS-1:0]       pick_i,
  output logic [WIDTH-1:0]       word_o
);
  localparam int BANK_BITS = SLOTS * WIDTH;

  logic [WIDTH-1:0]     chosen;
  logic [BANK_BITS-1:0] bank_w;

  assign bank_w = bank_i;

  top_index_pick #(.WIDTH(WIDTH), .SLOTS(SLOTS)) u_pick (
    .fallback_i (fallback_i),
    .bank_i     (bank_w),
    .pick_i     (pick_i),
    .word_o     (chosen)
  );

  if (MODE == MUX_SAFE) begin : g_safe
    logic many;
    pick_census #(.SLOTS(SLOTS)) u_census (
      .pick_i (pick_i),
      .many_o (many)
    );
    assign word_o = many ? fallback_i : chosen;
  end else begin : g_plain
    assign word_o = chosen;
  end
endmodule

// File: rtl/slice_select_mux_chk.sv
module slice_select_mux_chk
  import slice_mux_pkg::*;
#(
  parameter int        WIDTH = 8,
  parameter int        SLOTS = 4,
  parameter mux_mode_e MODE  = MUX_PLAIN
) (
  input logic [WIDTH-1:0]       fallback_i,
  input logic [SLOTS*WIDTH-1:0] bank_i,
  input logic [SLOTS-1:0]       pick_i,
  input logic [WIDTH-1:0]       word_o
);
  logic [WIDTH-1:0] hi_slice;
  int               n_set;

  always_comb begin
    hi_slice = fallback_i;
    n_set    = 0;
    for (int k = 0; k < SLOTS; k++) begin
      if (pick_i[k]) begin
        hi_slice = bank_i[k*WIDTH +: WIDTH];
        n_set    = n_set + 1;
      end
    end
  end

  always_comb begin
    // R2
    if (pick_i == '0)
      a_r2_idle_default: assert (word_o == fallback_i);
    // R1 / R5
    if (n_set == 1)
      a_r1_single_slice: assert (word_o == hi_slice);
    // R3
    if (MODE == MUX_PLAIN && n_set > 1)
      a_r3_top_index_wins: assert (word_o == hi_slice);
    // R4
    if (MODE == MUX_SAFE && n_set > 1)
      a_r4_safe_overlap_default: assert (word_o == fallback_i);
  end
endmodule

bind slice_select_mux slice_select_mux_chk #(.WIDTH(WIDTH), .SLOTS(SLOTS), .MODE(MODE)) u_chk (
  .fallback_i (fallback_i),
  .bank_i     (bank_i),
  .pick_i     (pick_i),
  .word_o     (word_o)
);

// File: tb/sim_slice_select_mux.sv
`timescale 1ns/1ps
module sim_slice_select_mux;
  import slice_mux_pkg::*;

  localparam int W = 6;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [W-1:0]   dflt;
  logic [N*W-1:0] bank;
  logic [N-1:0]   pick;
  logic [W-1:0]   y_plain;
  logic [W-1:0]   y_safe;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  slice_select_mux #(.WIDTH(W), .SLOTS(N), .MODE(MUX_PLAIN)) u0 (
    .fallback_i (dflt), .bank_i (bank), .pick_i (pick), .word_o (y_plain));
  slice_select_mux #(.WIDTH(W), .SLOTS(N), .MODE(MUX_SAFE)) u1 (
    .fallback_i (dflt), .bank_i (bank), .pick_i (pick), .word_o (y_safe));

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s pick=%b got=%h exp=%h", tag, pick, got, exp);
    end
  endtask

  // Distinct data: slices at offsets 3,14,25,36,47 and default at 58, plus seed.
  task automatic load(input int seed, input logic [N-1:0] p);
    dflt = W'(58 + seed);
    for (int k = 0; k < N; k++) bank[k*W +: W] = W'(k*11 + 3 + seed);
    pick = p;
    #1;
  endtask

  function automatic logic [W-1:0] slice_of(input int k);
    return bank[k*W +: W];
  endfunction

  function automatic logic [W-1:0] ref_plain();
    logic [W-1:0] r = dflt;
    for (int k = 0; k < N; k++) if (pick[k]) r = slice_of(k);
    return r;
  endfunction

  function automatic logic [W-1:0] ref_safe();
    int c = 0;
    for (int k = 0; k < N; k++) if (pick[k]) c++;
    return (c > 1) ? dflt : ref_plain();
  endfunction

  task automatic t_reset_state();
    load(0, '0);
    check("R2 reset plain", y_plain, dflt);
    check("R2 reset safe", y_safe, dflt);
  endtask

  task automatic t_single();
    for (int k = 0; k < N; k++) begin
      load(k + 1, N'(1) << k);
      check("R1 single plain", y_plain, slice_of(k));
      check("R5 single safe", y_safe, slice_of(k));
    end
  endtask

  task automatic t_none();
    load(9, '0);
    check("R2 none plain", y_plain, dflt);
    check("R2 none safe", y_safe, dflt);
  endtask

  task automatic t_multi();
    load(2, 5'b00011); check("R3 pair low", y_plain, slice_of(1));
    check("R4 pair low", y_safe, dflt);
    load(4, 5'b10001); check("R3 ends", y_plain, slice_of(4));
    check("R4 ends", y_safe, dflt);
    load(6, 5'b01110); check("R3 middle", y_plain, slice_of(3));
    check("R4 middle", y_safe, dflt);
    load(8, 5'b11111); check("R3 all", y_plain, slice_of(4));
    check("R4 all", y_safe, dflt);
  endtask

  task automatic t_exhaustive();
    for (int p = 0; p < (1 << N); p++) begin
      load(p, N'(p));
      check("R3 sweep plain", y_plain, ref_plain());
      check("R4 sweep safe", y_safe, ref_safe());
    end
  endtask

  task automatic t_no_state();
    load(3, 5'b00100);
    load(3, 5'b11000);
    load(3, 5'b00100);
    check("R6 reapply plain", y_plain, slice_of(2));
    check("R6 reapply safe", y_safe, slice_of(2));
    load(3, 5'b11000);
    check("R6 reapply multi plain", y_plain, slice_of(4));
    check("R6 reapply multi safe", y_safe, dflt);
  endtask

  initial begin
    dflt = '0; bank = '0; pick = '0;
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_single();
    t_none();
    t_multi();
    t_exhaustive();
    t_no_state();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule